// File: doc/BRIEF.md
# Tagged Bit Packer with Dropping Word Queue

This block sits behind a PDM capture front end. Each cycle it may receive one captured bit that carries a lane number and a slot number. Every lane/slot pair is a separate channel with its own packing register. Bits fill that register from the least significant position upward. When a channel has collected a full word, the word leaves the packer together with its lane ID, its slot ID and a running sequence number, and it is offered to a small FIFO.

The FIFO drives a valid/ready output stream. Capture never waits for the consumer. If a word completes while the FIFO is full and nothing leaves in that cycle, the word is discarded. The block then sets a sticky overflow flag and increments a drop counter. Sequence numbers are assigned to dropped words as well, so a gap in the output sequence shows where words were lost.

The block also counts the bits it accepts and the output handshakes. An asynchronous active-low reset and a one-cycle synchronous clear both return it to its empty state.

Top module: `tagged_bit_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `overflow` is 0, and all three counters are 0.
- R2: Each lane/slot channel packs its own bits. The first accepted bit of a word goes to bit 0 and the last goes to bit WORD_BITS-1. Bits for different channels may be interleaved and do not mix. When the FIFO was empty, the completed word is on the output in the cycle after the edge that accepted its last bit.
- R3: Each output word carries on `out_lane` and `out_slot` the lane and slot of the channel that produced it.
- R4: The sequence number starts at 0 after reset or clear. It increments by one for every completed word, whether the word is stored or dropped, and wraps at SEQ_BITS. Each word carries the value the counter had when the word completed.
- R5: The FIFO holds up to 2^FIFO_ADDR_BITS words. Words leave in the order in which they completed, one word per cycle in which `out_valid` and `out_ready` are both 1. `out_valid` is 1 exactly when the FIFO is not empty.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_lane`, `out_slot` and `out_seq` stay unchanged.
- R7: Suppose a word completes while the FIFO is full and no word leaves in that cycle. The word is discarded, `drop_count` increments by one and `overflow` becomes 1.
- R8: Once set, `overflow` stays 1 until reset or clear. Draining the FIFO does not clear it.
- R9: Suppose a word completes while the FIFO is full and a word leaves in the same cycle. The new word is stored and no drop is counted.
- R10: `bit_count` increments once for every accepted bit. `word_count` increments once for every output handshake. Both wrap at STAT_BITS.
- R11: A cycle with `clear` at 1 has the following effects at the next edge:
  - the FIFO is emptied;
  - every partial word is discarded;
  - the sequence number, all counters and `overflow` return to 0.
  
  A bit or handshake presented in that same cycle has no effect.
- R12: A bit whose lane is not below LANES, or whose slot is not below SLOTS, is ignored. It is neither counted nor packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous one-cycle clear of all state |
| in_valid | input | 1 | A captured bit is presented this cycle |
| in_bit | input | 1 | Value of the captured bit |
| in_lane | input | LANE_ID_BITS | Lane number of the bit |
| in_slot | input | SLOT_ID_BITS | Slot number of the bit |
| out_valid | output | 1 | A packed word is available |
| out_ready | input | 1 | Consumer takes the current word |
| out_data | output | WORD_BITS | Packed word, first bit in bit 0 |
| out_lane | output | LANE_ID_BITS | Lane number of the word |
| out_slot | output | SLOT_ID_BITS | Slot number of the word |
| out_seq | output | SEQ_BITS | Sequence number of the word |
| overflow | output | 1 | Sticky flag: at least one word was dropped |
| bit_count | output | STAT_BITS | Number of accepted bits |
| word_count | output | STAT_BITS | Number of output handshakes |
| drop_count | output | STAT_BITS | Number of dropped words |

## Verification
A single-channel byte sent with the consumer stalled shows the LSB-first fill order and the hold rule. Interleaving two channels bit by bit shows whether the packing registers stay apart, and whether each word is tagged with the right lane and slot.

A burst of words against a stalled consumer separates stored words from dropped ones, and shows the sequence gaps. A word that completes in the same cycle as a pop on a full queue tells the pop-first rule apart from a premature drop.

Out-of-range lane numbers, a clear that arrives mid-word alongside an incoming bit, and a long stretch of random bits, tags, stalls and occasional clears complete the picture. A queue-based reference model checks all of these on every clock.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    // Outcome of offering a completed word to the queue in one cycle.
    typedef enum logic [1:0] {
        PUSH_NONE    = 2'd0,
        PUSH_STORED  = 2'd1,
        PUSH_DROPPED = 2'd2
    } push_res_e;

endpackage

// File: rtl/tbp_packer.sv
module tbp_packer #(
    parameter int LANES        = 1,
    parameter int SLOTS        = 1,
    parameter int WORD_BITS    = 64,
    parameter int LANE_ID_BITS = 1,
    parameter int SLOT_ID_BITS = 1,
    parameter int SEQ_BITS     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic                    in_bit,
    input  logic [LANE_ID_BITS-1:0] in_lane,
    input  logic [SLOT_ID_BITS-1:0] in_slot,
    output logic                    bit_taken,
    output logic                    word_valid,
    output logic [WORD_BITS-1:0]    word_data,
    output logic [LANE_ID_BITS-1:0] word_lane,
    output logic [SLOT_ID_BITS-1:0] word_slot,
    output logic [SEQ_BITS-1:0]     word_seq
);

    localparam int CHANS = LANES * SLOTS;
    localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1;
    localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [CNT_W-1:0]      LAST     = CNT_W'(WORD_BITS - 1);
    localparam logic [LANE_ID_BITS:0] LANE_LIM = (LANE_ID_BITS + 1)'(LANES);
    localparam logic [SLOT_ID_BITS:0] SLOT_LIM = (SLOT_ID_BITS + 1)'(SLOTS);

    typedef struct packed {
        logic [CHANS-1:0][WORD_BITS-1:0] sh;
        logic [CHANS-1:0][CNT_W-1:0]     fill;
        logic [SEQ_BITS-1:0]             seq;
    } pack_st_t;

    pack_st_t            st_d, st_q;
    logic                in_range;
    logic                take;
    logic [CH_W-1:0]     chan;
    logic [WORD_BITS-1:0] nxt;

    assign in_range  = ({1'b0, in_lane} < LANE_LIM) && ({1'b0, in_slot} < SLOT_LIM);
    assign chan      = CH_W'(in_lane) * CH_W'(SLOTS) + CH_W'(in_slot);
    assign word_lane = in_lane;
    assign word_slot = in_slot;
    assign word_seq  = st_q.seq;

    always_comb begin
        st_d       = st_q;
        take       = in_valid && in_range && !clear;
        bit_taken  = 1'b0;
        word_valid = 1'b0;
        word_data  = '0;
        nxt        = '0;
        if (clear) begin
            st_d = '0;
        end else if (take) begin
            bit_taken = 1'b1;
            for (int c = 0; c < CHANS; c++) begin
                if (chan == CH_W'(c)) begin
                    nxt = st_q.sh[c];
                    nxt[st_q.fill[c]] = in_bit;
                    if (st_q.fill[c] == LAST) begin
                        word_valid   = 1'b1;
                        word_data    = nxt;
                        st_d.sh[c]   = '0;
                        st_d.fill[c] = '0;
                        st_d.seq     = st_q.seq + SEQ_BITS'(1);
                    end else begin
                        st_d.sh[c]   = nxt;
                        st_d.fill[c] = st_q.fill[c] + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: every completed word advances the sequence by exactly one
    assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> st_q.seq == $past(st_q.seq) + SEQ_BITS'(1));

    // R12: out-of-range tags never count as accepted bits
    assert_range_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> !bit_taken);

endmodule

// File: rtl/tbp_fifo.sv
module tbp_fifo #(
    parameter int WIDTH     = 98,
    parameter int ADDR_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                push,
    input  logic [WIDTH-1:0]    push_data,
    input  logic                pop_ready,
    output logic                rd_valid,
    output logic [WIDTH-1:0]    rd_data,
    output tbp_pkg::push_res_e  result
);
    import tbp_pkg::*;

    localparam int DEPTH = 1 << ADDR_BITS;
    localparam logic [ADDR_BITS:0] FULL_CNT = (ADDR_BITS + 1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [ADDR_BITS-1:0]        wr;
        logic [ADDR_BITS-1:0]        rd;
        logic [ADDR_BITS:0]          count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     pop;
    logic     full;
    logic     store;

    assign rd_valid = (st_q.count != '0);
    assign rd_data  = st_q.mem[st_q.rd];

    always_comb begin
        st_d   = st_q;
        full   = (st_q.count == FULL_CNT);
        pop    = rd_valid && pop_ready && !clear;
        store  = push && !clear && (!full || pop);
        result = PUSH_NONE;
        if (clear) begin
            st_d.wr    = '0;
            st_d.rd    = '0;
            st_d.count = '0;
        end else begin
            if (push) result = store ? PUSH_STORED : PUSH_DROPPED;
            if (store) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = st_q.wr + ADDR_BITS'(1);
            end
            if (pop) st_d.rd = st_q.rd + ADDR_BITS'(1);
            case ({store, pop})
                2'b10:   st_d.count = st_q.count + (ADDR_BITS + 1)'(1);
                2'b01:   st_d.count = st_q.count - (ADDR_BITS + 1)'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: occupancy never exceeds the configured depth
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);

    // R7 / R9: a word is dropped only on a full queue with no pop that cycle
    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result == PUSH_DROPPED) |-> (st_q.count == FULL_CNT) && !pop_ready);

endmodule

// File: rtl/tbp_stats.sv
module tbp_stats #(
    parameter int STAT_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 bit_taken,
    input  logic                 handshake,
    input  tbp_pkg::push_res_e   result,
    output logic [STAT_BITS-1:0] bits,
    output logic [STAT_BITS-1:0] words,
    output logic [STAT_BITS-1:0] drops,
    output logic                 overflow
);
    import tbp_pkg::*;

    typedef struct packed {
        logic [STAT_BITS-1:0] bits;
        logic [STAT_BITS-1:0] words;
        logic [STAT_BITS-1:0] drops;
        logic                 ovf;
    } stat_st_t;

    stat_st_t st_d, st_q;

    assign bits     = st_q.bits;
    assign words    = st_q.words;
    assign drops    = st_q.drops;
    assign overflow = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (bit_taken) st_d.bits  = st_q.bits + STAT_BITS'(1);
            if (handshake) st_d.words = st_q.words + STAT_BITS'(1);
            if (result == PUSH_DROPPED) begin
                st_d.drops = st_q.drops + STAT_BITS'(1);
                st_d.ovf   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: the overflow flag holds until clear
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    // R10: each handshake advances the word counter by one
    assert_words_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (handshake && !clear) |=> words == $past(words) + STAT_BITS'(1));

    // R7: each drop advances the drop counter and raises overflow
    assert_drop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result == PUSH_DROPPED && !clear) |=> (drops == $past(drops) + STAT_BITS'(1)) && overflow);

endmodule

// File: rtl/tagged_bit_packer.sv
module tagged_bit_packer #(
    parameter int LANES          = 1,
    parameter int SLOTS          = 1,
    parameter int WORD_BITS      = 64,
    parameter int FIFO_ADDR_BITS = 4,
    parameter int LANE_ID_BITS   = 1,
    parameter int SLOT_ID_BITS   = 1,
    parameter int SEQ_BITS       = 32,
    parameter int STAT_BITS      = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic                    in_bit,
    input  logic [LANE_ID_BITS-1:0] in_lane,
    input  logic [SLOT_ID_BITS-1:0] in_slot,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORD_BITS-1:0]    out_data,
    output logic [LANE_ID_BITS-1:0] out_lane,
    output logic [SLOT_ID_BITS-1:0] out_slot,
    output logic [SEQ_BITS-1:0]     out_seq,
    output logic                    overflow,
    output logic [STAT_BITS-1:0]    bit_count,
    output logic [STAT_BITS-1:0]    word_count,
    output logic [STAT_BITS-1:0]    drop_count
);
    import tbp_pkg::*;

    localparam int ENTRY_W = SEQ_BITS + SLOT_ID_BITS + LANE_ID_BITS + WORD_BITS;

    logic                    bit_taken;
    logic                    word_valid;
    logic [WORD_BITS-1:0]    word_data;
    logic [LANE_ID_BITS-1:0] word_lane;
    logic [SLOT_ID_BITS-1:0] word_slot;
    logic [SEQ_BITS-1:0]     word_seq;
    logic [ENTRY_W-1:0]      push_entry;
    logic [ENTRY_W-1:0]      head_entry;
    logic                    handshake;
    push_res_e               push_res;

    tbp_packer #(
        .LANES(LANES), .SLOTS(SLOTS), .WORD_BITS(WORD_BITS),
        .LANE_ID_BITS(LANE_ID_BITS), .SLOT_ID_BITS(SLOT_ID_BITS), .SEQ_BITS(SEQ_BITS)
    ) u_packer (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .in_valid(in_valid), .in_bit(in_bit), .in_lane(in_lane), .in_slot(in_slot),
        .bit_taken(bit_taken), .word_valid(word_valid), .word_data(word_data),
        .word_lane(word_lane), .word_slot(word_slot), .word_seq(word_seq)
    );

    assign push_entry = {word_seq, word_slot, word_lane, word_data};

    tbp_fifo #(
        .WIDTH(ENTRY_W), .ADDR_BITS(FIFO_ADDR_BITS)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(word_valid), .push_data(push_entry), .pop_ready(out_ready),
        .rd_valid(out_valid), .rd_data(head_entry), .result(push_res)
    );

    assign {out_seq, out_slot, out_lane, out_data} = head_entry;
    assign handshake = out_valid && out_ready && !clear;

    tbp_stats #(
        .STAT_BITS(STAT_BITS)
    ) u_stats (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .bit_taken(bit_taken), .handshake(handshake), .result(push_res),
        .bits(bit_count), .words(word_count), .drops(drop_count), .overflow(overflow)
    );

    // R6: a stalled output word holds all of its fields
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clear) |=>
            (out_valid && $stable(out_data) && $stable(out_lane)
             && $stable(out_slot) && $stable(out_seq)));

    // R11: one clear cycle returns the block to its empty state
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && !overflow && bit_count == '0
                   && word_count == '0 && drop_count == '0));

endmodule

// File: tb/tagged_bit_packer_test.sv
module tagged_bit_packer_test;

    localparam int LANES = 3;
    localparam int SLOTS = 2;
    localparam int WB    = 8;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic [1:0]  in_lane = '0;
    logic [0:0]  in_slot = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [1:0]  out_lane;
    logic [0:0]  out_slot;
    logic [7:0]  out_seq;
    logic        overflow;
    logic [15:0] bit_count, word_count, drop_count;

    int nchecks = 0;
    int nfails  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tagged_bit_packer #(
        .LANES(LANES), .SLOTS(SLOTS), .WORD_BITS(WB), .FIFO_ADDR_BITS(2),
        .LANE_ID_BITS(2), .SLOT_ID_BITS(1), .SEQ_BITS(8), .STAT_BITS(16)
    ) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .in_valid(in_valid), .in_bit(in_bit), .in_lane(in_lane), .in_slot(in_slot),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_lane(out_lane), .out_slot(out_slot), .out_seq(out_seq),
        .overflow(overflow), .bit_count(bit_count), .word_count(word_count),
        .drop_count(drop_count)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_word [LANES*SLOTS];
    int          m_fill [LANES*SLOTS];
    logic [7:0]  q_data [$];
    logic [1:0]  q_lane [$];
    logic [0:0]  q_slot [$];
    logic [7:0]  q_seq  [$];
    logic [7:0]  m_seq;
    logic [15:0] m_bits, m_words, m_drops;
    logic        m_ovf;

    task automatic model_reset();
        for (int c = 0; c < LANES*SLOTS; c++) begin
            m_word[c] = '0;
            m_fill[c] = 0;
        end
        q_data.delete(); q_lane.delete(); q_slot.delete(); q_seq.delete();
        m_seq = '0; m_bits = '0; m_words = '0; m_drops = '0; m_ovf = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || clear) begin
            model_reset();
        end else begin
            bit         do_pop;
            bit         do_push;
            logic [7:0] pw;
            int         c;
            do_pop  = (q_data.size() != 0) && out_ready;
            do_push = 1'b0;
            pw      = '0;
            if (in_valid && int'(in_lane) < LANES && int'(in_slot) < SLOTS) begin
                m_bits = m_bits + 16'd1;
                c = int'(in_lane) * SLOTS + int'(in_slot);
                m_word[c][m_fill[c]] = in_bit;
                m_fill[c] = m_fill[c] + 1;
                if (m_fill[c] == WB) begin
                    do_push   = 1'b1;
                    pw        = m_word[c];
                    m_word[c] = '0;
                    m_fill[c] = 0;
                end
            end
            if (do_pop) begin
                void'(q_data.pop_front()); void'(q_lane.pop_front());
                void'(q_slot.pop_front()); void'(q_seq.pop_front());
                m_words = m_words + 16'd1;
            end
            if (do_push) begin
                if (q_data.size() < DEPTH) begin
                    q_data.push_back(pw); q_lane.push_back(in_lane);
                    q_slot.push_back(in_slot); q_seq.push_back(m_seq);
                end else begin
                    m_drops = m_drops + 16'd1;
                    m_ovf   = 1'b1;
                end
                m_seq = m_seq + 8'd1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit mv;
        mv = (q_data.size() != 0);
        check(out_valid == mv, "R5", "out_valid", longint'(out_valid), longint'(mv));
        if (mv && out_valid) begin
            check(out_data == q_data[0], "R2", "out_data", longint'(out_data), longint'(q_data[0]));
            check(out_lane == q_lane[0], "R3", "out_lane", longint'(out_lane), longint'(q_lane[0]));
            check(out_slot == q_slot[0], "R3", "out_slot", longint'(out_slot), longint'(q_slot[0]));
            check(out_seq == q_seq[0], "R4", "out_seq", longint'(out_seq), longint'(q_seq[0]));
        end
        check(overflow == m_ovf, "R8", "overflow", longint'(overflow), longint'(m_ovf));
        check(bit_count == m_bits, "R10", "bit_count", longint'(bit_count), longint'(m_bits));
        check(word_count == m_words, "R10", "word_count", longint'(word_count), longint'(m_words));
        check(drop_count == m_drops, "R7", "drop_count", longint'(drop_count), longint'(m_drops));
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(input bit v, input bit b, input logic [1:0] l,
                        input logic [0:0] s, input bit r, input bit c);
        @(negedge clk);
        compare_all();
        in_valid = v; in_bit = b; in_lane = l; in_slot = s;
        out_ready = r; clear = c;
    endtask

    task automatic idle(input bit r, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 1'b0, r, 1'b0);
    endtask

    task automatic send_word(input logic [1:0] l, input logic [0:0] s,
                             input logic [7:0] w, input bit r);
        for (int i = 0; i < WB; i++) step(1'b1, w[i], l, s, r, 1'b0);
    endtask

    task automatic send_pair(input logic [1:0] l1, input logic [0:0] s1, input logic [7:0] w1,
                             input logic [1:0] l2, input logic [0:0] s2, input logic [7:0] w2,
                             input bit r);
        for (int i = 0; i < WB; i++) begin
            step(1'b1, w1[i], l1, s1, r, 1'b0);
            step(1'b1, w2[i], l2, s2, r, 1'b0);
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nfails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  held;
        logic [15:0] drops_before;
        logic [15:0] bits_before;

        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        check(overflow == 1'b0, "R1", "overflow after reset", longint'(overflow), 0);
        check(bit_count == 0 && word_count == 0 && drop_count == 0, "R1", "counters after reset",
              longint'(bit_count) + longint'(word_count) + longint'(drop_count), 0);

        // R2: LSB-first fill, stalled consumer
        send_word(2'd0, 1'b0, 8'hA5, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        check(out_valid && out_data == 8'hA5, "R2", "first packed word", longint'(out_data), 64'hA5);
        check(out_seq == 8'd0, "R4", "first sequence", longint'(out_seq), 0);

        // R6: stall holds the word
        held = out_data;
        idle(1'b0, 5);
        check(out_valid && out_data == held && out_seq == 8'd0, "R6", "stalled word",
              longint'(out_data), longint'(held));

        // R3 / R7: interleaved channels, then overflow the 4-entry queue
        send_pair(2'd1, 1'b1, 8'h3C, 2'd2, 1'b0, 8'hF0, 1'b0);
        send_word(2'd2, 1'b1, 8'h81, 1'b0);
        send_pair(2'd0, 1'b1, 8'h12, 2'd1, 1'b0, 8'hEE, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        check(drop_count == 16'd2, "R7", "drops after burst", longint'(drop_count), 2);
        check(overflow == 1'b1, "R7", "overflow after drop", longint'(overflow), 1);

        // R9: completion on a full queue in the same cycle as a pop
        drops_before = drop_count;
        for (int i = 0; i < WB - 1; i++) step(1'b1, i[0], 2'd2, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        check(drop_count == drops_before, "R9", "no drop on push with pop",
              longint'(drop_count), longint'(drops_before));
        check(word_count == 16'd1, "R10", "one handshake", longint'(word_count), 1);

        // R8: drain, overflow stays set
        idle(1'b1, 8);
        check(!out_valid && overflow, "R8", "overflow after drain", longint'(overflow), 1);
        check(word_count == 16'd5, "R10", "handshakes after drain", longint'(word_count), 5);

        // R12: out-of-range lane is ignored
        bits_before = bit_count;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
        check(bit_count == bits_before && !out_valid, "R12", "ignored lane 3",
              longint'(bit_count), longint'(bits_before));

        // R11: clear mid-word with a bit presented in the same cycle
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        check(!overflow && bit_count == 0 && word_count == 0 && drop_count == 0 && !out_valid,
              "R11", "state after clear", longint'(bit_count) + longint'(overflow), 0);
        send_word(2'd0, 1'b0, 8'h06, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        check(out_data == 8'h06, "R11", "partial word discarded", longint'(out_data), 64'h06);
        check(out_seq == 8'd0, "R11", "sequence restarted", longint'(out_seq), 0);
        idle(1'b1, 2);

        // random traffic, stalls and rare clears
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] rl;
            rl = 2'($urandom % 4);
            step(($urandom % 10) < 7, 1'($urandom), rl, 1'($urandom),
                 ($urandom % 3) != 0, ($urandom % 700) == 0);
        end
        idle(1'b1, 10);
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

endmodule